// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Controller

This block moves words from peripherals into memory while the processor stays out of the way. Each channel has a programmed start address and a programmed word count. When the channel is enabled, the controller copies both into working registers. The working registers advance with every word moved, and the programmed values stay as they were written. A peripheral that wants service raises its request line. The controller then asks the processor for the buses. It waits for the grant, and only after that does it drive the memory address and the write strobe and raise the acknowledge line of the channel it is serving. The peripheral places its data on the bus during that acknowledge cycle.

Four transfer modes decide when the controller gives the buses back. Single mode returns them after one word. Block mode keeps them until the count runs out. Demand mode keeps them only while the request stays high. Cycle-steal mode hands the processor one cycle between consecutive words. When a channel's working count reaches zero, the channel disables itself, sets a sticky status flag and raises a one-cycle completion pulse.

The sequencer has four states:
- ST_IDLE: no bus request.
- ST_REQ: bus request raised, waiting for the grant.
- ST_XFER: one word is written per cycle.
- ST_YIELD: one cycle with the request dropped, used by cycle-steal mode.

Its transitions are:
- ST_IDLE to ST_REQ, when a channel is eligible; the served channel is latched at this step.
- ST_REQ to ST_XFER, when the grant is seen.
- ST_XFER to ST_IDLE, at the last word, after a single-mode word, or when a demand-mode request has dropped.
- ST_XFER to ST_YIELD, for a cycle-steal mode word that is not the last.
- ST_XFER to ST_REQ, when the grant is lost.
- ST_XFER to ST_XFER, to continue.
- ST_YIELD to ST_REQ, always.

Top module: `pdma_ctrl`

## Requirements
- R1: After reset the bus request, write strobe, acknowledges and completion pulses are low, and every register reads zero.
- R2: Register select codes on cfg_sel are: 0 start address, 1 word count, 2 control, 3 status, 4 working address (read only), 5 working count (read only). Control holds bit 0 = enable and bits 2:1 = mode. Writing control with bit 0 set copies the programmed address and count into the working registers. Transfers never change the programmed values.
- R3: A channel is eligible when it is enabled, its working count is nonzero and its request line is high. An eligible channel in ST_IDLE raises bus_req one cycle later. A channel whose count is zero never raises bus_req.
- R4: mem_we and chan_ack rise only on a clock edge at which bus_grant was high.
- R5: In a transfer cycle exactly one chan_ack bit is high, the one of the served channel, mem_we is high, and mem_addr equals that channel's working address. Outside a transfer cycle mem_addr is zero.
- R6: Each transfer adds one to the working address and subtracts one from the working count.
- R7: The transfer that takes the count from 1 to 0 is followed by a one-cycle tc_done pulse for that channel. That transfer also sets the channel's status bit 0, clears its enable bit and returns the sequencer to ST_IDLE.
- R8: In mode 0 (single), the controller moves one word and then drops bus_req.
- R9: In mode 1 (block), the controller keeps writing on consecutive cycles until the count is exhausted.
- R10: In mode 2 (demand), the controller keeps writing while the channel's request is high and stops at the first transfer cycle in which it is low.
- R11: In mode 3 (cycle steal), bus_req is low for one cycle between any two words of a channel.
- R12: Among eligible channels, the lowest index is served. A channel being served is not preempted.
- R13: If bus_grant is low during a block transfer cycle, that word still completes. The controller then keeps bus_req high with no acknowledge until the grant returns, and then resumes.
- R14: Writing status with bit 0 set clears the flag. If the clear lands in the same cycle as the terminal transfer, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_ch | input | CIW | Channel addressed by the register access |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| chan_req | input | NCH | Peripheral service requests |
| chan_ack | output | NCH | Peripheral acknowledges, one-hot during a transfer |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Processor has released the buses |
| mem_addr | output | AW | Memory address of the current word |
| mem_we | output | 1 | Memory write strobe |
| tc_done | output | NCH | One-cycle terminal-count pulses |

## Verification
A processor write that clears a channel's status flag can land on the same clock edge as that channel's terminal transfer, which sets the flag. The bench waits for the acknowledge cycle of the final word, at the address one below the end. It issues the status clear at the next falling edge, so both actions take effect on the same rising edge. It then reads status and expects the flag set. A behavioural model, updated every clock, also predicts the request, acknowledge, strobe, address and completion outputs. The model follows lost grants and mode changes, and the bench compares its prediction with the outputs every cycle.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_DEMAND = 2'd2,
        XM_STEAL  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_XFER  = 2'd2,
        ST_YIELD = 2'd3
    } seq_state_e;

    localparam logic [2:0] SEL_BASE_ADDR = 3'd0;
    localparam logic [2:0] SEL_BASE_CNT  = 3'd1;
    localparam logic [2:0] SEL_CTRL      = 3'd2;
    localparam logic [2:0] SEL_STATUS    = 3'd3;
    localparam logic [2:0] SEL_WORK_ADDR = 3'd4;
    localparam logic [2:0] SEL_WORK_CNT  = 3'd5;

endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            step,
    output logic [AW-1:0]   base_addr,
    output logic [CW-1:0]   base_cnt,
    output logic [AW-1:0]   work_addr,
    output logic [CW-1:0]   work_cnt,
    output logic            enable,
    output xfer_mode_e      mode,
    output logic            tc_flag,
    output logic            done
);

    logic at_end;
    logic load;

    assign at_end = (work_cnt == CW'(1));
    assign load   = wr_en && (wr_sel == SEL_CTRL) && wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            work_addr <= '0;
            work_cnt  <= '0;
            enable    <= 1'b0;
            mode      <= XM_SINGLE;
            tc_flag   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= step && at_end;
            if (step) begin
                work_addr <= work_addr + AW'(1);
                work_cnt  <= work_cnt - CW'(1);
                if (at_end) begin
                    enable <= 1'b0;
                end
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_BASE_ADDR: base_addr <= wr_data[AW-1:0];
                    SEL_BASE_CNT:  base_cnt  <= wr_data[CW-1:0];
                    SEL_CTRL: begin
                        enable <= wr_data[0];
                        mode   <= xfer_mode_e'(wr_data[2:1]);
                        if (wr_data[0]) begin
                            work_addr <= base_addr;
                            work_cnt  <= base_cnt;
                        end
                    end
                    default: ;
                endcase
            end
            if (wr_en && (wr_sel == SEL_STATUS) && wr_data[0]) begin
                tc_flag <= 1'b0;
            end
            if (step && at_end) begin
                tc_flag <= 1'b1;
            end
        end
    end

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(step) && ($past(work_cnt) == CW'(1))));

    // R6
    addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (work_addr == $past(work_addr) + AW'(1)));

    // R14
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_end) |=> tc_flag);

endmodule

// File: rtl/pdma_arb.sv
module pdma_arb #(
    parameter int NCH = 4,
    parameter int CIW = 2
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] gnt,
    output logic [CIW-1:0] idx,
    output logic           any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = NCH'(1) << i;
                idx = CIW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int CIW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_grant,
    input  logic           any_elig,
    input  logic [CIW-1:0] win_idx,
    input  xfer_mode_e     cur_mode,
    input  logic           cur_last,
    input  logic           cur_req,
    output logic           bus_req,
    output logic           xfer,
    output logic [CIW-1:0] cur_idx
);

    seq_state_e state;
    seq_state_e next;

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE: begin
                if (any_elig) next = ST_REQ;
            end
            ST_REQ: begin
                if (bus_grant) next = ST_XFER;
            end
            ST_XFER: begin
                if (cur_last || (cur_mode == XM_SINGLE) ||
                    ((cur_mode == XM_DEMAND) && !cur_req)) begin
                    next = ST_IDLE;
                end else if (cur_mode == XM_STEAL) begin
                    next = ST_YIELD;
                end else if (!bus_grant) begin
                    next = ST_REQ;
                end else begin
                    next = ST_XFER;
                end
            end
            ST_YIELD: next = ST_REQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            state <= next;
            if ((state == ST_IDLE) && any_elig) begin
                cur_idx <= win_idx;
            end
        end
    end

    always_comb begin
        bus_req = (state == ST_REQ) || (state == ST_XFER);
        xfer    = (state == ST_XFER);
    end

    // R4
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer) |-> $past(bus_grant));

    // R11
    yield_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_XFER) && (cur_mode == XM_STEAL) && !cur_last) |=> !bus_req);

endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
    import pdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DW  = 32,
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CIW-1:0]  cfg_ch,
    input  logic [2:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic [NCH-1:0]  chan_req,
    output logic [NCH-1:0]  chan_ack,
    output logic            bus_req,
    input  logic            bus_grant,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [NCH-1:0]  tc_done
);

    logic [AW-1:0]  base_addr_a [NCH];
    logic [CW-1:0]  base_cnt_a  [NCH];
    logic [AW-1:0]  work_addr_a [NCH];
    logic [CW-1:0]  work_cnt_a  [NCH];
    xfer_mode_e     mode_a      [NCH];
    logic [NCH-1:0] enable_v;
    logic [NCH-1:0] tc_v;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] step_v;
    logic [NCH-1:0] arb_gnt;
    logic [CIW-1:0] arb_idx;
    logic           arb_any;
    logic           xfer;
    logic [CIW-1:0] cur_idx;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic wr_hit;
        assign wr_hit    = cfg_we && (cfg_ch == CIW'(g));
        assign elig[g]   = enable_v[g] && (work_cnt_a[g] != '0) && chan_req[g];
        assign step_v[g] = xfer && (cur_idx == CIW'(g));

        pdma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_hit),
            .wr_sel    (cfg_sel),
            .wr_data   (cfg_wdata),
            .step      (step_v[g]),
            .base_addr (base_addr_a[g]),
            .base_cnt  (base_cnt_a[g]),
            .work_addr (work_addr_a[g]),
            .work_cnt  (work_cnt_a[g]),
            .enable    (enable_v[g]),
            .mode      (mode_a[g]),
            .tc_flag   (tc_v[g]),
            .done      (tc_done[g])
        );
    end

    pdma_arb #(.NCH(NCH), .CIW(CIW)) u_arb (
        .req (elig),
        .gnt (arb_gnt),
        .idx (arb_idx),
        .any (arb_any)
    );

    pdma_seq #(.CIW(CIW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_grant (bus_grant),
        .any_elig  (arb_any),
        .win_idx   (arb_idx),
        .cur_mode  (mode_a[cur_idx]),
        .cur_last  (work_cnt_a[cur_idx] == CW'(1)),
        .cur_req   (chan_req[cur_idx]),
        .bus_req   (bus_req),
        .xfer      (xfer),
        .cur_idx   (cur_idx)
    );

    assign chan_ack = step_v;
    assign mem_we   = xfer;
    assign mem_addr = xfer ? work_addr_a[cur_idx] : '0;

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_BASE_ADDR: cfg_rdata = DW'(base_addr_a[cfg_ch]);
            SEL_BASE_CNT:  cfg_rdata = DW'(base_cnt_a[cfg_ch]);
            SEL_CTRL:      cfg_rdata = DW'({2'(mode_a[cfg_ch]), enable_v[cfg_ch]});
            SEL_STATUS:    cfg_rdata = DW'(tc_v[cfg_ch]);
            SEL_WORK_ADDR: cfg_rdata = DW'(work_addr_a[cfg_ch]);
            SEL_WORK_CNT:  cfg_rdata = DW'(work_cnt_a[cfg_ch]);
            default:       cfg_rdata = '0;
        endcase
    end

    // R5
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_ack));

    // R12
    prio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_any |-> ((elig & (arb_gnt - NCH'(1))) == '0));

endmodule

// File: tb/tb_pdma_ctrl.sv
`timescale 1ns/1ps
module tb_pdma_ctrl;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int DW  = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [2:0]     cfg_sel = '0;
    logic [DW-1:0]  cfg_wdata = '0;
    logic [DW-1:0]  cfg_rdata;
    logic [NCH-1:0] chan_req = '0;
    logic [NCH-1:0] chan_ack;
    logic           bus_req;
    logic           bus_grant;
    logic [AW-1:0]  mem_addr;
    logic           mem_we;
    logic [NCH-1:0] tc_done;
    bit             cpu_allow = 1'b1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    pdma_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .chan_req(chan_req), .chan_ack(chan_ack), .bus_req(bus_req),
        .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_we(mem_we),
        .tc_done(tc_done)
    );

    // processor: grants one cycle after the request, unless held off
    always @(posedge clk) begin
        if (!rst_n) bus_grant <= 1'b0;
        else        bus_grant <= bus_req & cpu_allow;
    end

    // behavioural reference model
    int            m_st = 0;
    int            m_cur = 0;
    logic [AW-1:0] m_ba [NCH];
    logic [AW-1:0] m_wa [NCH];
    logic [CW-1:0] m_bc [NCH];
    logic [CW-1:0] m_wc [NCH];
    bit            m_en [NCH];
    int            m_mode [NCH];
    bit            m_tc [NCH];
    logic [NCH-1:0] m_done = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cur = 0; m_done = '0;
            for (int i = 0; i < NCH; i++) begin
                m_ba[i] = '0; m_wa[i] = '0; m_bc[i] = '0; m_wc[i] = '0;
                m_en[i] = 0; m_mode[i] = 0; m_tc[i] = 0;
            end
        end else begin
            int nst;
            int ncur;
            bit term;
            int c;
            nst = m_st; ncur = m_cur; term = 0; c = m_cur;
            m_done = '0;
            if (m_st == 0) begin
                for (int i = NCH - 1; i >= 0; i--)
                    if (m_en[i] && m_wc[i] != 0 && chan_req[i]) begin
                        nst = 1; ncur = i;
                    end
            end else if (m_st == 1) begin
                if (bus_grant) nst = 2;
            end else if (m_st == 2) begin
                term = (m_wc[c] == 1);
                if (term || m_mode[c] == 0 || (m_mode[c] == 2 && !chan_req[c])) nst = 0;
                else if (m_mode[c] == 3) nst = 3;
                else if (!bus_grant) nst = 1;
                else nst = 2;
                m_wa[c] = m_wa[c] + 1'b1;
                m_wc[c] = m_wc[c] - 1'b1;
                if (term) begin
                    m_en[c] = 0;
                    m_done[c] = 1'b1;
                end
            end else begin
                nst = 1;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_ba[cfg_ch] = cfg_wdata[AW-1:0];
                    3'd1: m_bc[cfg_ch] = cfg_wdata[CW-1:0];
                    3'd2: begin
                        m_en[cfg_ch] = cfg_wdata[0];
                        m_mode[cfg_ch] = int'(cfg_wdata[2:1]);
                        if (cfg_wdata[0]) begin
                            m_wa[cfg_ch] = m_ba[cfg_ch];
                            m_wc[cfg_ch] = m_bc[cfg_ch];
                        end
                    end
                    3'd3: if (cfg_wdata[0]) m_tc[cfg_ch] = 0;
                    default: ;
                endcase
            end
            if (term) m_tc[c] = 1;
            m_st = nst; m_cur = ncur;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk("R3 bus_req", 64'(bus_req), 64'(m_st == 1 || m_st == 2));
            chk("R5 chan_ack", 64'(chan_ack), (m_st == 2) ? 64'(NCH'(1) << m_cur) : 64'd0);
            chk("R4 mem_we", 64'(mem_we), 64'(m_st == 2));
            chk("R5 mem_addr", 64'(mem_addr), (m_st == 2) ? 64'(m_wa[m_cur]) : 64'd0);
            chk("R7 tc_done", 64'(tc_done), 64'(m_done));
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 60000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            report();
        end
    end

    // called just after a falling edge
    task automatic wr(input int ch, input int sel, input int data);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = DW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, input logic [63:0] exp, input string tag);
        cfg_ch = 2'(ch); cfg_sel = 3'(sel);
        #1;
        chk(tag, 64'(cfg_rdata), exp);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seen;
        int guard;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus_req", 64'(bus_req), 0);
        rd(0, 1, 0, "R1 count");
        rd(2, 5, 0, "R1 work count");
        rd(3, 3, 0, "R1 status");

        // R9 block on channel 0
        wr(0, 0, 'h100); wr(0, 1, 3); wr(0, 2, 3);
        rd(0, 4, 'h100, "R2 work addr loaded");
        rd(0, 5, 3, "R2 work count loaded");
        chan_req[0] = 1'b1;
        idle(20);
        chan_req[0] = 1'b0;
        rd(0, 4, 'h103, "R6 work addr advanced");
        rd(0, 5, 0, "R9 count exhausted");
        rd(0, 0, 'h100, "R2 base addr kept");
        rd(0, 1, 3, "R2 base count kept");
        rd(0, 3, 1, "R7 status set");
        rd(0, 2, 2, "R7 enable cleared");
        wr(0, 3, 1);
        rd(0, 3, 0, "R14 status cleared");

        // R3 zero count never requests the bus
        wr(1, 1, 0); wr(1, 2, 1);
        chan_req[1] = 1'b1;
        seen = 0;
        repeat (10) begin @(negedge clk); if (bus_req) seen++; end
        chan_req[1] = 1'b0;
        chk("R3 zero count bus_req cycles", 64'(seen), 0);

        // R8 single mode
        wr(1, 0, 'h200); wr(1, 1, 2); wr(1, 2, 1);
        chan_req[1] = 1'b1;
        idle(20);
        chan_req[1] = 1'b0;
        rd(1, 4, 'h202, "R8 single addr");
        rd(1, 3, 1, "R8 single status");

        // R10 demand mode, request dropped early
        wr(2, 0, 'h300); wr(2, 1, 8); wr(2, 2, 5);
        chan_req[2] = 1'b1;
        idle(5);
        chan_req[2] = 1'b0;
        idle(10);
        rd(2, 5, 64'(m_wc[2]), "R10 demand remaining");
        rd(2, 3, 0, "R10 demand not terminal");

        // R11 cycle steal
        wr(3, 0, 'h400); wr(3, 1, 3); wr(3, 2, 7);
        chan_req[3] = 1'b1;
        idle(30);
        chan_req[3] = 1'b0;
        rd(3, 4, 'h403, "R11 steal addr");

        // R12 priority
        wr(1, 0, 'h500); wr(1, 1, 1); wr(1, 2, 1);
        wr(2, 0, 'h600); wr(2, 1, 1); wr(2, 2, 1);
        chan_req[1] = 1'b1; chan_req[2] = 1'b1;
        guard = 0;
        while (chan_ack == '0 && guard < 50) begin @(negedge clk); guard++; end
        chk("R12 first served", 64'(chan_ack), 64'h2);
        idle(20);
        chan_req[1] = 1'b0; chan_req[2] = 1'b0;
        rd(2, 4, 'h601, "R12 second served");

        // R13 grant lost mid block
        wr(0, 0, 'h700); wr(0, 1, 6); wr(0, 2, 3);
        chan_req[0] = 1'b1;
        guard = 0;
        while (!chan_ack[0] && guard < 50) begin @(negedge clk); guard++; end
        cpu_allow = 1'b0;
        idle(4);
        cpu_allow = 1'b1;
        idle(30);
        chan_req[0] = 1'b0;
        rd(0, 4, 'h706, "R13 resumed addr");
        rd(0, 5, 0, "R13 resumed count");

        // R14 clear and terminal set in the same cycle
        wr(0, 3, 1);
        wr(0, 0, 'h800); wr(0, 1, 2); wr(0, 2, 3);
        chan_req[0] = 1'b1;
        guard = 0;
        while (!(chan_ack[0] && mem_addr == 16'h801) && guard < 50) begin
            @(negedge clk); guard++;
        end
        wr(0, 3, 1);
        chan_req[0] = 1'b0;
        idle(3);
        rd(0, 3, 1, "R14 set wins over clear");

        idle(5);
        report();
    end
endmodule